// File: doc/BRIEF.md
# Reorder Buffer with Youngest-Producer Lookup

This block keeps the program order of in-flight instructions in a small dual-issue out-of-order core. Each cycle, up to two instructions claim slots at the tail of a 16-slot circular buffer. Each claimed slot returns a slot number (its tag). Results arrive out of order on a common data bus addressed by that tag. Finished slots retire one per cycle from the head, in program order, and each retirement writes the destination register of the register file. A slot whose result carries an exception does not retire. It raises an exception output carrying its PC and empties the buffer. An external flush input, used for a mispredicted branch, also empties the buffer.

Every cycle, four source-operand names (two per issuing instruction) are compared against the destination name of every occupied slot. For each name, the youngest matching slot wins. The search walks backwards from the tail and wraps around the ring. The answer takes one of three forms:

- no producer is in flight, so the operand is read from the register file;
- the producer has finished, so its value is forwarded;
- the producer is pending, so its tag is returned to wait on.

Top module: `rob_core`

## Requirements
- R1: After reset the buffer is empty. `alloc_ready` is 1 when nothing is requested. `cmt_valid`, `exc_valid` and every `lk_hit` bit are 0.
- R2: Requests claim slots in program order. Lane 0 gets the tail slot. Lane 1 gets the next slot if lane 0 also requests, and the tail slot itself if lane 0 does not. `alloc0_tag` and `alloc1_tag` show these slot numbers combinationally.
- R3: `alloc_ready` is 0 whenever the occupied count at the start of the cycle plus the number of requests exceeds 16. A request for two slots with one slot free stalls both lanes, and neither lane claims a slot.
- R4: A bus write with `cdb_valid` stores `cdb_value` and `cdb_exc` into the occupied slot named by `cdb_tag` and marks that slot finished.
- R5: A lookup reports one of three outcomes. No occupied slot matches: `lk_hit`=0. The matching slot has finished: `lk_hit`=1, `lk_ready`=1, and `lk_value` holds the result. The matching slot is pending: `lk_hit`=1, `lk_ready`=0, and `lk_tag` holds the slot number.
- R6: When several occupied slots hold the same destination, the lookup answers with the most recently claimed one. This holds when that slot sits at a lower slot number than an older match, because the tail has wrapped.
- R7: When the head slot has finished without an exception, `cmt_valid` is 1 with its destination and value for one cycle, and the head moves on by one. Retirement follows program order whatever the order in which results arrived, at most one slot per cycle.
- R8: When the head slot has finished with its exception flag set:
  - `exc_valid` is 1 with that slot's PC, and `cmt_valid` is 0;
  - `alloc_ready` is 0;
  - in the next cycle the buffer is empty.
- R9: When `flush_in` is high, the following happen together:
  - every slot not retiring that cycle is freed at the next edge;
  - the tail returns to the head;
  - `alloc_ready` is 0;
  - a retirement presented in the same cycle still completes.
- R10: All 16 slots are usable. An extra wrap bit on the head and tail pointers tells full from empty. Claiming and retiring may occur in the same cycle, and the freed slot number is handed out again after the ring wraps.
- R11: Lookups reflect the buffer state at the start of the cycle. A bus write or a claim in the same cycle is visible to lookups from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| alloc0_valid | input | 1 | Lane 0 requests a slot (older instruction) |
| alloc0_dest | input | 6 | Lane 0 destination register |
| alloc0_pc | input | 32 | Lane 0 instruction address |
| alloc1_valid | input | 1 | Lane 1 requests a slot (younger instruction) |
| alloc1_dest | input | 6 | Lane 1 destination register |
| alloc1_pc | input | 32 | Lane 1 instruction address |
| alloc_ready | output | 1 | Requests of this cycle are accepted |
| alloc0_tag | output | 4 | Slot given to lane 0 |
| alloc1_tag | output | 4 | Slot given to lane 1 |
| cdb_valid | input | 1 | Result broadcast present |
| cdb_tag | input | 4 | Slot the result belongs to |
| cdb_value | input | 32 | Result value |
| cdb_exc | input | 1 | Result raised an exception |
| lk_name | input | 4x6 | Source register names, one per lookup port |
| lk_hit | output | 4 | An in-flight producer exists |
| lk_ready | output | 4 | That producer has finished |
| lk_tag | output | 4x4 | Slot of the youngest producer |
| lk_value | output | 4x32 | Forwarded value when ready |
| cmt_valid | output | 1 | Register file write from the head slot |
| cmt_dest | output | 6 | Register written |
| cmt_value | output | 32 | Value written |
| exc_valid | output | 1 | Head slot raised an exception; buffer is emptied |
| exc_pc | output | 32 | Address of the faulting instruction |
| flush_in | input | 1 | Discard all speculative slots |

## Verification
The interesting collisions are a retirement at the head coinciding with a claim at the tail, and a retirement coinciding with a flush.

For the first case, the bench fills all sixteen slots so that the tail has wrapped. It then finishes two head slots on successive cycles. The second retirement lands on a cycle where one slot is free, and a new claim is requested in that same cycle. The bench judges the claim by the reused slot number it receives, and by the scoreboard seeing the retirement in order.

For the second case, a finished head slot is presented together with `flush_in`. The scoreboard must see that retirement. Afterwards, lookups must miss and the next claim must start at the advanced head.

// File: rtl/rob_pkg.sv
package rob_pkg;

    parameter int unsigned ROB_ENTRIES  = 16;
    parameter int unsigned ARCH_REGS    = 64;
    parameter int unsigned DATA_W       = 32;
    parameter int unsigned PC_W         = 32;
    parameter int unsigned LOOKUP_PORTS = 4;

    localparam int unsigned IDX_W = $clog2(ROB_ENTRIES);
    localparam int unsigned PTR_W = IDX_W + 1;
    localparam int unsigned REG_W = $clog2(ARCH_REGS);
    localparam int unsigned CNT_W = $clog2(ROB_ENTRIES + 1);

    typedef logic [IDX_W-1:0] rob_idx_t;
    typedef logic [PTR_W-1:0] rob_ptr_t;
    typedef logic [REG_W-1:0] reg_name_t;

    typedef struct packed {
        logic              busy;
        logic              done;
        logic              exc;
        reg_name_t         dest;
        logic [PC_W-1:0]   pc;
        logic [DATA_W-1:0] value;
    } rob_entry_t;

    typedef struct packed {
        rob_entry_t [ROB_ENTRIES-1:0] ent;
        rob_ptr_t                     head;
        rob_ptr_t                     tail;
    } rob_state_t;

    typedef struct packed {
        logic              hit;
        logic              ready;
        rob_idx_t          tag;
        logic [DATA_W-1:0] value;
    } lookup_rsp_t;

endpackage

// File: rtl/rob_occupancy.sv
module rob_occupancy
    import rob_pkg::*;
(
    input  rob_ptr_t         head,
    input  rob_ptr_t         tail,
    input  logic [1:0]       n_req,
    output logic [CNT_W-1:0] used,
    output logic             fits
);

    logic [CNT_W:0] demand;

    always_comb begin
        used   = CNT_W'(tail - head);
        demand = {1'b0, used} + (CNT_W+1)'(n_req);
        fits   = (demand <= (CNT_W+1)'(ROB_ENTRIES));
    end

endmodule

// File: rtl/rob_lookup.sv
module rob_lookup
    import rob_pkg::*;
(
    input  rob_entry_t [ROB_ENTRIES-1:0] ent,
    input  rob_idx_t                     tail_idx,
    input  reg_name_t                    name,
    output lookup_rsp_t                  rsp
);

    rob_idx_t probe;
    logic     found;

    // Walk from the newest slot (tail - 1) backwards around the ring;
    // the first occupied match is the youngest producer.
    always_comb begin
        rsp   = '0;
        found = 1'b0;
        probe = '0;
        for (int k = 0; k < int'(ROB_ENTRIES); k++) begin
            probe = tail_idx - rob_idx_t'(k + 1);
            if (!found && ent[probe].busy && (ent[probe].dest == name)) begin
                found     = 1'b1;
                rsp.hit   = 1'b1;
                rsp.ready = ent[probe].done;
                rsp.tag   = probe;
                rsp.value = ent[probe].done ? ent[probe].value : '0;
            end
        end
    end

endmodule

// File: rtl/rob_core.sv
module rob_core
    import rob_pkg::*;
(
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                alloc0_valid,
    input  logic [REG_W-1:0]                    alloc0_dest,
    input  logic [PC_W-1:0]                     alloc0_pc,
    input  logic                                alloc1_valid,
    input  logic [REG_W-1:0]                    alloc1_dest,
    input  logic [PC_W-1:0]                     alloc1_pc,
    output logic                                alloc_ready,
    output logic [IDX_W-1:0]                    alloc0_tag,
    output logic [IDX_W-1:0]                    alloc1_tag,
    input  logic                                cdb_valid,
    input  logic [IDX_W-1:0]                    cdb_tag,
    input  logic [DATA_W-1:0]                   cdb_value,
    input  logic                                cdb_exc,
    input  logic [LOOKUP_PORTS-1:0][REG_W-1:0]  lk_name,
    output logic [LOOKUP_PORTS-1:0]             lk_hit,
    output logic [LOOKUP_PORTS-1:0]             lk_ready,
    output logic [LOOKUP_PORTS-1:0][IDX_W-1:0]  lk_tag,
    output logic [LOOKUP_PORTS-1:0][DATA_W-1:0] lk_value,
    output logic                                cmt_valid,
    output logic [REG_W-1:0]                    cmt_dest,
    output logic [DATA_W-1:0]                   cmt_value,
    output logic                                exc_valid,
    output logic [PC_W-1:0]                     exc_pc,
    input  logic                                flush_in
);

    rob_state_t       st_q, st_d;
    rob_ptr_t         head_q, tail_q;
    rob_idx_t         head_idx, tail_idx;
    rob_entry_t       head_ent;
    logic [1:0]       n_req;
    logic [CNT_W-1:0] occ_used;
    logic             occ_fits;
    logic             head_fin, cmt_fire, exc_fire;

    assign head_q   = st_q.head;
    assign tail_q   = st_q.tail;
    assign head_idx = head_q[IDX_W-1:0];
    assign tail_idx = tail_q[IDX_W-1:0];
    assign head_ent = st_q.ent[head_idx];
    assign n_req    = {1'b0, alloc0_valid} + {1'b0, alloc1_valid};

    rob_occupancy u_occ (
        .head  (head_q),
        .tail  (tail_q),
        .n_req (n_req),
        .used  (occ_used),
        .fits  (occ_fits)
    );

    // Retirement / exception decision at the head
    always_comb begin
        head_fin    = head_ent.busy && head_ent.done;
        cmt_fire    = head_fin && !head_ent.exc;
        exc_fire    = head_fin && head_ent.exc;
        cmt_valid   = cmt_fire;
        cmt_dest    = head_ent.dest;
        cmt_value   = head_ent.value;
        exc_valid   = exc_fire;
        exc_pc      = head_ent.pc;
        alloc_ready = occ_fits && !flush_in && !exc_fire;
        alloc0_tag  = tail_idx;
        alloc1_tag  = tail_idx + rob_idx_t'(alloc0_valid);
    end

    // Next-state computation
    always_comb begin
        st_d = st_q;

        if (cdb_valid && st_q.ent[cdb_tag].busy) begin
            st_d.ent[cdb_tag].done  = 1'b1;
            st_d.ent[cdb_tag].value = cdb_value;
            st_d.ent[cdb_tag].exc   = cdb_exc;
        end

        if (cmt_fire) begin
            st_d.ent[head_idx].busy = 1'b0;
            st_d.ent[head_idx].done = 1'b0;
            st_d.head               = st_q.head + rob_ptr_t'(1);
        end

        if (alloc_ready) begin
            if (alloc0_valid) begin
                st_d.ent[alloc0_tag] = '{busy: 1'b1, done: 1'b0, exc: 1'b0,
                                         dest: alloc0_dest, pc: alloc0_pc,
                                         value: '0};
            end
            if (alloc1_valid) begin
                st_d.ent[alloc1_tag] = '{busy: 1'b1, done: 1'b0, exc: 1'b0,
                                         dest: alloc1_dest, pc: alloc1_pc,
                                         value: '0};
            end
            st_d.tail = st_q.tail + rob_ptr_t'(n_req);
        end

        if (flush_in || exc_fire) begin
            for (int e = 0; e < int'(ROB_ENTRIES); e++) begin
                st_d.ent[e].busy = 1'b0;
                st_d.ent[e].done = 1'b0;
                st_d.ent[e].exc  = 1'b0;
            end
            st_d.tail = st_d.head;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // Parallel associative lookups
    for (genvar g = 0; g < int'(LOOKUP_PORTS); g++) begin : g_lookup
        lookup_rsp_t rsp;

        rob_lookup u_lk (
            .ent      (st_q.ent),
            .tail_idx (tail_idx),
            .name     (lk_name[g]),
            .rsp      (rsp)
        );

        assign lk_hit[g]   = rsp.hit;
        assign lk_ready[g] = rsp.ready;
        assign lk_tag[g]   = rsp.tag;
        assign lk_value[g] = rsp.value;
    end

endmodule

// File: rtl/rob_core_chk.sv
module rob_core_chk
    import rob_pkg::*;
(
    input logic                    clk,
    input logic                    rst_n,
    input logic                    flush_in,
    input logic                    exc_valid,
    input logic                    cmt_valid,
    input logic                    alloc_ready,
    input logic [LOOKUP_PORTS-1:0] lk_hit,
    input logic [LOOKUP_PORTS-1:0] lk_ready,
    input rob_ptr_t                head_q,
    input rob_ptr_t                tail_q,
    input logic [CNT_W-1:0]        used
);

    // R10: occupancy never exceeds the ring size
    a_r10_capacity: assert property (@(posedge clk) disable iff (!rst_n)
        used <= CNT_W'(ROB_ENTRIES));

    // R3: a refused cycle leaves the tail where it was
    a_r3_stall_holds_tail: assert property (@(posedge clk) disable iff (!rst_n)
        (!alloc_ready && !flush_in && !exc_valid) |=> (tail_q == $past(tail_q)));

    // R7: a retirement advances the head by exactly one
    a_r7_commit_advances: assert property (@(posedge clk) disable iff (!rst_n)
        cmt_valid |=> (head_q == $past(head_q) + rob_ptr_t'(1)));

    // R7: without a retirement the head stays put
    a_r7_head_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !cmt_valid |=> $stable(head_q));

    // R8 / R9: after a flush or exception the buffer is empty
    a_r9_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
        (flush_in || exc_valid) |=> ((used == '0) && !cmt_valid && !exc_valid && (lk_hit == '0)));

    // R8: an exception never retires
    a_r8_exc_no_commit: assert property (@(posedge clk) disable iff (!rst_n)
        exc_valid |-> !cmt_valid);

    // R5: a ready answer always comes with a hit
    a_r5_ready_needs_hit: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_ready & ~lk_hit) == '0);

endmodule

bind rob_core rob_core_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .flush_in    (flush_in),
    .exc_valid   (exc_valid),
    .cmt_valid   (cmt_valid),
    .alloc_ready (alloc_ready),
    .lk_hit      (lk_hit),
    .lk_ready    (lk_ready),
    .head_q      (head_q),
    .tail_q      (tail_q),
    .used        (occ_used)
);

// File: tb/rob_core_bench.sv
module rob_core_bench;
    import rob_pkg::*;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #10 clk = ~clk;

    logic                                alloc0_valid, alloc1_valid;
    logic [REG_W-1:0]                    alloc0_dest, alloc1_dest;
    logic [PC_W-1:0]                     alloc0_pc, alloc1_pc;
    logic                                alloc_ready;
    logic [IDX_W-1:0]                    alloc0_tag, alloc1_tag;
    logic                                cdb_valid, cdb_exc;
    logic [IDX_W-1:0]                    cdb_tag;
    logic [DATA_W-1:0]                   cdb_value;
    logic [LOOKUP_PORTS-1:0][REG_W-1:0]  lk_name;
    logic [LOOKUP_PORTS-1:0]             lk_hit, lk_ready;
    logic [LOOKUP_PORTS-1:0][IDX_W-1:0]  lk_tag;
    logic [LOOKUP_PORTS-1:0][DATA_W-1:0] lk_value;
    logic                                cmt_valid, exc_valid, flush_in;
    logic [REG_W-1:0]                    cmt_dest;
    logic [DATA_W-1:0]                   cmt_value;
    logic [PC_W-1:0]                     exc_pc;

    rob_core u_rob_core (
        .clk(clk), .rst_n(rst_n),
        .alloc0_valid(alloc0_valid), .alloc0_dest(alloc0_dest), .alloc0_pc(alloc0_pc),
        .alloc1_valid(alloc1_valid), .alloc1_dest(alloc1_dest), .alloc1_pc(alloc1_pc),
        .alloc_ready(alloc_ready), .alloc0_tag(alloc0_tag), .alloc1_tag(alloc1_tag),
        .cdb_valid(cdb_valid), .cdb_tag(cdb_tag), .cdb_value(cdb_value), .cdb_exc(cdb_exc),
        .lk_name(lk_name), .lk_hit(lk_hit), .lk_ready(lk_ready), .lk_tag(lk_tag),
        .lk_value(lk_value), .cmt_valid(cmt_valid), .cmt_dest(cmt_dest),
        .cmt_value(cmt_value), .exc_valid(exc_valid), .exc_pc(exc_pc),
        .flush_in(flush_in)
    );

    typedef struct {
        logic [REG_W-1:0]  dest;
        logic [DATA_W-1:0] val;
    } exp_t;

    exp_t expq[$];
    int   vectors = 0;
    int   miscompares = 0;
    bit   done_flag = 1'b0;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        vectors++;
        if (!ok) begin
            miscompares++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic cyc();
        @(posedge clk);
        #1;
    endtask

    task automatic idle();
        alloc0_valid = 1'b0; alloc1_valid = 1'b0;
        alloc0_dest = '0; alloc1_dest = '0; alloc0_pc = '0; alloc1_pc = '0;
        cdb_valid = 1'b0; cdb_tag = '0; cdb_value = '0; cdb_exc = 1'b0;
        flush_in = 1'b0;
    endtask

    task automatic req0(input logic [REG_W-1:0] d, input logic [PC_W-1:0] pc);
        alloc0_valid = 1'b1; alloc0_dest = d; alloc0_pc = pc;
    endtask

    task automatic req1(input logic [REG_W-1:0] d, input logic [PC_W-1:0] pc);
        alloc1_valid = 1'b1; alloc1_dest = d; alloc1_pc = pc;
    endtask

    task automatic push(input logic [REG_W-1:0] d, input logic [DATA_W-1:0] v);
        exp_t e;
        e.dest = d; e.val = v;
        expq.push_back(e);
    endtask

    task automatic bcast(input logic [IDX_W-1:0] t, input logic [DATA_W-1:0] v, input logic x);
        cdb_valid = 1'b1; cdb_tag = t; cdb_value = v; cdb_exc = x;
    endtask

    function automatic logic [REG_W-1:0] fill_dest(input int i);
        return (i == 0 || i == 14) ? REG_W'(40) : REG_W'(10 + i);
    endfunction

    // Scoreboard monitor: R7 in-order retirement
    always @(negedge clk) begin
        if (rst_n && cmt_valid) begin
            if (expq.size() == 0) begin
                chk(1'b0, "R7", "unexpected retirement dest", 64'(cmt_dest), 64'hFFFF);
            end else begin
                exp_t e;
                e = expq.pop_front();
                chk(cmt_dest == e.dest, "R7", "retired dest", 64'(cmt_dest), 64'(e.dest));
                chk(cmt_value == e.val, "R7", "retired value", 64'(cmt_value), 64'(e.val));
            end
        end
    end

    task automatic finish_run();
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done_flag) begin
            miscompares++;
            $display("FAIL watchdog: actual hung expected finished");
            finish_run();
        end
    end

    initial begin
        idle();
        lk_name = '0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1 reset state
        @(negedge clk);
        chk(alloc_ready == 1'b1, "R1", "alloc_ready", 64'(alloc_ready), 1);
        chk(cmt_valid == 1'b0, "R1", "cmt_valid", 64'(cmt_valid), 0);
        chk(exc_valid == 1'b0, "R1", "exc_valid", 64'(exc_valid), 0);
        chk(lk_hit == '0, "R1", "lk_hit", 64'(lk_hit), 0);

        // R2 two lanes in order
        cyc();
        req0(6'd5, 32'h100); req1(6'd7, 32'h104);
        @(negedge clk);
        chk(alloc_ready, "R2", "ready", 64'(alloc_ready), 1);
        chk(alloc0_tag == 4'd0, "R2", "lane0 tag", 64'(alloc0_tag), 0);
        chk(alloc1_tag == 4'd1, "R2", "lane1 tag", 64'(alloc1_tag), 1);
        push(6'd5, 32'h1111); push(6'd7, 32'h2222);
        cyc(); idle();

        // R5 three outcomes (pending / miss)
        lk_name[0] = 6'd5; lk_name[1] = 6'd7; lk_name[2] = 6'd9; lk_name[3] = 6'd5;
        @(negedge clk);
        chk(lk_hit[0] && !lk_ready[0] && lk_tag[0] == 4'd0, "R5", "pending tag p0", 64'(lk_tag[0]), 0);
        chk(lk_hit[1] && !lk_ready[1] && lk_tag[1] == 4'd1, "R5", "pending tag p1", 64'(lk_tag[1]), 1);
        chk(!lk_hit[2], "R5", "miss p2", 64'(lk_hit[2]), 0);

        // R2 lane 1 alone takes the tail slot
        cyc();
        req1(6'd5, 32'h108);
        @(negedge clk);
        chk(alloc1_tag == 4'd2, "R2", "lane1 alone tag", 64'(alloc1_tag), 2);
        push(6'd5, 32'hAAAA);
        cyc(); idle();

        // R6 youngest producer
        @(negedge clk);
        chk(lk_hit[3] && lk_tag[3] == 4'd2, "R6", "youngest tag", 64'(lk_tag[3]), 2);

        // R4 / R11 bus write
        cyc();
        bcast(4'd2, 32'hAAAA, 1'b0);
        @(negedge clk);
        chk(!lk_ready[0], "R11", "same-cycle write hidden", 64'(lk_ready[0]), 0);
        cyc(); idle();
        @(negedge clk);
        chk(lk_ready[0] && lk_value[0] == 32'hAAAA, "R4", "forwarded value", 64'(lk_value[0]), 64'hAAAA);
        chk(!cmt_valid, "R7", "no retire before head done", 64'(cmt_valid), 0);

        // R7 out-of-order completion, in-order retirement
        cyc();
        bcast(4'd1, 32'h2222, 1'b0);
        cyc();
        bcast(4'd0, 32'h1111, 1'b0);
        cyc(); idle();
        repeat (4) cyc();
        chk(expq.size() == 0, "R7", "queue drained", 64'(expq.size()), 0);

        // R10 fill all sixteen slots, tail starts at 3
        for (int p = 0; p < 7; p++) begin
            req0(fill_dest(2*p), PC_W'(32'h400 + 8*p));
            req1(fill_dest(2*p+1), PC_W'(32'h404 + 8*p));
            @(negedge clk);
            chk(alloc_ready && alloc0_tag == IDX_W'(3 + 2*p), "R10", "fill tag", 64'(alloc0_tag), 64'(IDX_W'(3 + 2*p)));
            push(fill_dest(2*p), DATA_W'(32'h1000 + 2*p));
            push(fill_dest(2*p+1), DATA_W'(32'h1000 + 2*p + 1));
            cyc(); idle();
        end
        req0(fill_dest(14), 32'h438);
        @(negedge clk);
        chk(alloc0_tag == 4'd1, "R10", "wrapped tag", 64'(alloc0_tag), 1);
        push(fill_dest(14), 32'h100E);
        cyc(); idle();

        // R3 two requests with one slot free stall both
        req0(6'd33, 32'h43C); req1(6'd34, 32'h440);
        @(negedge clk);
        chk(!alloc_ready, "R3", "pair refused", 64'(alloc_ready), 0);
        cyc(); idle();
        req0(fill_dest(15), 32'h43C);
        @(negedge clk);
        chk(alloc_ready && alloc0_tag == 4'd2, "R3", "single accepted in last slot", 64'(alloc0_tag), 2);
        push(fill_dest(15), 32'h100F);
        cyc(); idle();
        req0(6'd35, 32'h444);
        @(negedge clk);
        chk(!alloc_ready, "R10", "full refuses", 64'(alloc_ready), 0);
        cyc(); idle();

        // R6 wrap: youngest dest-40 is slot 1, older is slot 3
        lk_name[0] = 6'd40; lk_name[1] = 6'd15;
        @(negedge clk);
        chk(lk_hit[0] && !lk_ready[0] && lk_tag[0] == 4'd1, "R6", "wrapped youngest", 64'(lk_tag[0]), 1);
        chk(lk_hit[1] && lk_tag[1] == 4'd8, "R6", "single match", 64'(lk_tag[1]), 8);

        // R10 claim and retire in the same cycle
        cyc();
        bcast(4'd3, 32'h1000, 1'b0);
        cyc(); idle();
        bcast(4'd4, 32'h1001, 1'b0);
        req0(6'd50, 32'h500);
        @(negedge clk);
        chk(!alloc_ready, "R10", "full while head retires", 64'(alloc_ready), 0);
        cyc(); idle();
        req0(6'd50, 32'h500);
        @(negedge clk);
        chk(cmt_valid, "R10", "retire this cycle", 64'(cmt_valid), 1);
        chk(alloc_ready && alloc0_tag == 4'd3, "R10", "reused slot", 64'(alloc0_tag), 3);
        push(6'd50, 32'h3000);
        cyc(); idle();
        req0(6'd51, 32'h504); req1(6'd52, 32'h508);
        @(negedge clk);
        chk(!alloc_ready, "R3", "pair refused at 15", 64'(alloc_ready), 0);
        cyc(); idle();

        // R9 flush with a retirement in the same cycle
        bcast(4'd5, 32'h1002, 1'b0);
        cyc(); idle();
        flush_in = 1'b1;
        req0(6'd53, 32'h50C);
        @(negedge clk);
        chk(!alloc_ready, "R9", "ready during flush", 64'(alloc_ready), 0);
        chk(cmt_valid && cmt_value == 32'h1002, "R9", "retire with flush", 64'(cmt_value), 64'h1002);
        cyc(); idle();
        expq.delete();
        req0(6'd53, 32'h50C);
        @(negedge clk);
        chk(!lk_hit[0] && !lk_hit[1], "R9", "lookups miss after flush", 64'(lk_hit), 0);
        chk(!cmt_valid, "R9", "nothing to retire", 64'(cmt_valid), 0);
        chk(alloc0_tag == 4'd6, "R9", "tail back at head", 64'(alloc0_tag), 6);
        idle();

        // R8 exception at head
        req0(6'd60, 32'h200); req1(6'd61, 32'h204);
        cyc(); idle();
        bcast(4'd6, 32'hDEAD, 1'b1);
        cyc(); idle();
        req0(6'd62, 32'h208);
        @(negedge clk);
        chk(exc_valid && exc_pc == 32'h200, "R8", "exception pc", 64'(exc_pc), 64'h200);
        chk(!cmt_valid, "R8", "no retire on exception", 64'(cmt_valid), 0);
        chk(!alloc_ready, "R8", "claims refused", 64'(alloc_ready), 0);
        cyc(); idle();
        lk_name[0] = 6'd61;
        req0(6'd1, 32'h300);
        @(negedge clk);
        chk(!exc_valid && !lk_hit[0], "R8", "buffer emptied", 64'(lk_hit[0]), 0);
        chk(alloc0_tag == 4'd6, "R8", "tail at head", 64'(alloc0_tag), 6);

        // R7 reverse-order completion
        req1(6'd2, 32'h304);
        push(6'd1, 32'h51); push(6'd2, 32'h52);
        cyc(); idle();
        req0(6'd3, 32'h308); req1(6'd4, 32'h30C);
        push(6'd3, 32'h53); push(6'd4, 32'h54);
        cyc(); idle();
        lk_name[0] = 6'd4;
        bcast(4'd9, 32'h54, 1'b0);
        @(negedge clk);
        chk(lk_hit[0] && !lk_ready[0] && lk_tag[0] == 4'd9, "R11", "not ready same cycle", 64'(lk_ready[0]), 0);
        cyc(); idle();
        bcast(4'd8, 32'h53, 1'b0);
        cyc(); idle();
        bcast(4'd7, 32'h52, 1'b0);
        cyc(); idle();
        bcast(4'd6, 32'h51, 1'b0);
        cyc(); idle();
        repeat (6) cyc();
        chk(expq.size() == 0, "R7", "all retired in order", 64'(expq.size()), 0);

        done_flag = 1'b1;
        finish_run();
    end

endmodule